// File: doc/BRIEF.md
# Address-Space-Tagged Page Translation Cache

This block is a small, fully associative cache of 4 KiB page translations. Every line holds an address-space identifier, a 20-bit virtual page number, a physical frame number and three permission bits (read, write, non-secure). A client presents an identifier and a 32-bit virtual address and receives hit, frame and permissions one cycle later. After a miss the block raises a busy flag and waits until a page-table walker delivers the translation on the fill port.

Software controls the cache through two write-only words. A configuration word limits how many lines take part in lookups and fills, and enables hit-under-miss. A flush word removes translations. It can remove every line, every line of one identifier, one 4 MiB section, or one 16 KiB group of four pages. The flush applies one cycle after the word is written.

Top module: `asid_tlb`

## Requirements
- R1: While reset is asserted and after it is released, `lk_ready` is high, `rsp_valid` and `walk_busy` are low, and every line is invalid, so the first lookup misses.
- R2: A lookup accepted on a clock edge (`lk_valid` and `lk_ready` both high) produces `rsp_valid` for one cycle after that edge. The result is a hit only when a valid line inside the active range matches both `lk_asid` and `lk_va[31:12]`. A hit returns that line's frame and permissions, coded as {read, write, non-secure} in bits 2..0. A miss returns zero in both.
- R3: A lookup that misses while `walk_busy` is low sets `walk_busy`. The first edge with `fill_valid` high clears it again.
- R4: Configuration bit 29 enables hit-under-miss. When it is clear, `lk_ready` is low while `walk_busy` is high and any lookup presented then is not accepted. When it is set, lookups stay accepted while busy and hits return normally.
- R5: The low `$clog2(ENTRIES+1)` bits of the configuration word set the active line count, clamped to ENTRIES. Lines at or above that index never hit and never receive fills, but they keep their contents until the count is raised again.
- R6: A fill overwrites a valid active line holding the same identifier and page. Otherwise it takes the lowest-numbered invalid active line. Otherwise it takes the line named by a round-robin pointer. The pointer starts at 0 and, after each such eviction, moves to the line after the victim, wrapping at the active count.
- R7: A flush word written on one edge invalidates lines on the next edge. A lookup accepted on that next edge still sees the lines as they were before the flush.
- R8: Flush bits [1:0] select the scope. Code 0 covers all pages. Code 2 covers pages whose VA[31:22] equals flush bits [19:10]. Code 3 covers pages whose VA[31:14] equals flush bits [19:2]. Code 1 invalidates nothing.
- R9: Flush bit 31 restricts the flush to lines whose identifier equals the flush identifier field. When bit 31 is clear, the identifier field is ignored.
- R10: With NUM_ASIDS of 128 the flush identifier field is bits [30:24]. With NUM_ASIDS of 4 it is bits [30:29].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_va | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | PFN_W | Physical frame number on a hit |
| rsp_perm | output | 3 | {read, write, non-secure} on a hit |
| walk_busy | output | 1 | A miss is waiting for a fill |
| fill_valid | input | 1 | Fill write strobe |
| fill_asid | input | ASID_W | Fill identifier |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_pfn | input | PFN_W | Fill frame number |
| fill_perm | input | 3 | Fill permissions |
| flush_we | input | 1 | Flush word write strobe |
| flush_cmd | input | 32 | Flush word |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word |

## Verification
A lookup result appears on the ports one cycle after the edge that accepts the request. The driver queues the expected result when it raises `lk_valid`, and the monitor compares each `rsp_valid` cycle against the head of that queue, so timing is checked along with data. `walk_busy` and `lk_ready` change on the accepting edge or the fill edge and are sampled one time step after it. A flush needs two edges, one to latch the word and one to apply it. The flush task therefore returns only after the first edge, and one test presents a lookup on the second edge to see the old contents.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES   = 8,
  parameter int NUM_ASIDS = 128,
  parameter int PFN_W     = 20,
  localparam int ASID_W   = $clog2(NUM_ASIDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [31:0]       lk_va,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [2:0]        rsp_perm,
  output logic              walk_busy,
  input  logic              fill_valid,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [19:0]       fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [2:0]        fill_perm,
  input  logic              flush_we,
  input  logic [31:0]       flush_cmd,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(ENTRIES + 1);
  localparam int FL_LO = (NUM_ASIDS == 4) ? 29 : 24;

  logic [ENTRIES-1:0] vld;
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [19:0]        e_vpn  [ENTRIES];
  logic [PFN_W-1:0]   e_pfn  [ENTRIES];
  logic [2:0]         e_perm [ENTRIES];

  logic [CNT_W-1:0] active;
  logic             hum;
  logic [IDX_W-1:0] rr;
  logic             fl_pend;
  logic [31:0]      fl_cmd;

  logic [ENTRIES-1:0] live, hitv, dupv, freev, kill;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_line
      logic in_range, asid_ok, scope_ok;
      assign in_range = CNT_W'(g) < active;
      assign live[g]  = vld[g] && in_range;
      assign freev[g] = !vld[g] && in_range;
      assign hitv[g]  = live[g] && e_asid[g] == lk_asid && e_vpn[g] == lk_va[31:12];
      assign dupv[g]  = live[g] && e_asid[g] == fill_asid && e_vpn[g] == fill_vpn;
      assign asid_ok  = !fl_cmd[31] || e_asid[g] == fl_cmd[FL_LO +: ASID_W];
      assign scope_ok = (fl_cmd[1:0] == 2'd0) ||
                        (fl_cmd[1:0] == 2'd2 && e_vpn[g][19:10] == fl_cmd[19:10]) ||
                        (fl_cmd[1:0] == 2'd3 && e_vpn[g][19:2]  == fl_cmd[19:2]);
      assign kill[g]  = fl_pend && asid_ok && scope_ok;
    end
  endgenerate

  logic             any_hit, acc, do_fill, use_rr;
  logic [IDX_W-1:0] hit_idx, dup_idx, free_idx, victim;
  logic [CNT_W:0]   rr_inc;

  assign any_hit  = |hitv;
  assign lk_ready = !walk_busy || hum;
  assign acc      = lk_valid && lk_ready;
  assign do_fill  = fill_valid && active != '0;
  assign use_rr   = !(|dupv) && !(|freev);

  always_comb begin
    hit_idx  = '0;
    dup_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitv[i])  hit_idx  = IDX_W'(i);
      if (dupv[i])  dup_idx  = IDX_W'(i);
      if (freev[i]) free_idx = IDX_W'(i);
    end
    if (|dupv)                     victim = dup_idx;
    else if (|freev)               victim = free_idx;
    else if (CNT_W'(rr) < active)  victim = rr;
    else                           victim = '0;
    rr_inc = (CNT_W+1)'(victim) + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      active    <= CNT_W'(ENTRIES);
      hum       <= 1'b0;
      rr        <= '0;
      fl_pend   <= 1'b0;
      fl_cmd    <= '0;
      walk_busy <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pfn   <= '0;
      rsp_perm  <= '0;
    end else begin
      fl_pend <= flush_we;
      if (flush_we) fl_cmd <= flush_cmd;
      if (cfg_we) begin
        hum    <= cfg_wdata[29];
        active <= (cfg_wdata[CNT_W-1:0] > CNT_W'(ENTRIES)) ? CNT_W'(ENTRIES)
                                                            : cfg_wdata[CNT_W-1:0];
      end
      vld <= vld & ~kill;
      if (do_fill) begin
        vld[victim]    <= 1'b1;
        e_asid[victim] <= fill_asid;
        e_vpn[victim]  <= fill_vpn;
        e_pfn[victim]  <= fill_pfn;
        e_perm[victim] <= fill_perm;
        if (use_rr)
          rr <= (rr_inc >= (CNT_W+1)'(active)) ? '0 : IDX_W'(rr_inc);
      end
      walk_busy <= walk_busy ? !fill_valid : (acc && !any_hit);
      rsp_valid <= acc;
      rsp_hit   <= acc && any_hit;
      rsp_pfn   <= (acc && any_hit) ? e_pfn[hit_idx]  : '0;
      rsp_perm  <= (acc && any_hit) ? e_perm[hit_idx] : '0;
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int PFN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic [2:0]       rsp_perm,
  input logic             walk_busy,
  input logic             fill_valid,
  input logic             hum
);
  assert_rsp_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_valid && lk_ready));

  assert_hit_has_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pfn == '0 && rsp_perm == 3'b000));

  assert_busy_from_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_busy) |-> (rsp_valid && !rsp_hit));

  assert_fill_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_busy && fill_valid) |=> !walk_busy);

  assert_stall_without_hum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_busy && !hum) |-> !lk_ready);
endmodule

bind asid_tlb asid_tlb_chk #(.PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm),
  .walk_busy(walk_busy), .fill_valid(fill_valid), .hum(hum)
);

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        lk_valid = 0, lk_ready, rsp_valid, rsp_hit, walk_busy;
  logic [6:0]  lk_asid = '0, fill_asid = '0;
  logic [31:0] lk_va = '0, flush_cmd = '0, cfg_wdata = '0;
  logic [19:0] rsp_pfn, fill_vpn = '0, fill_pfn = '0;
  logic [2:0]  rsp_perm, fill_perm = '0;
  logic        fill_valid = 0, flush_we = 0, cfg_we = 0;

  asid_tlb dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_asid(lk_asid), .lk_va(lk_va), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm), .walk_busy(walk_busy),
    .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .flush_we(flush_we),
    .flush_cmd(flush_cmd), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata)
  );

  logic        b_lk_valid = 0, b_lk_ready, b_rsp_valid, b_rsp_hit, b_busy;
  logic [1:0]  b_lk_asid = '0, b_fill_asid = '0;
  logic [31:0] b_lk_va = '0, b_flush_cmd = '0;
  logic [19:0] b_rsp_pfn, b_fill_vpn = '0, b_fill_pfn = '0;
  logic [2:0]  b_rsp_perm;
  logic        b_fill_valid = 0, b_flush_we = 0;

  asid_tlb #(.ENTRIES(4), .NUM_ASIDS(4)) dut_a4 (
    .clk(clk), .rst_n(rst_n), .lk_valid(b_lk_valid), .lk_ready(b_lk_ready),
    .lk_asid(b_lk_asid), .lk_va(b_lk_va), .rsp_valid(b_rsp_valid), .rsp_hit(b_rsp_hit),
    .rsp_pfn(b_rsp_pfn), .rsp_perm(b_rsp_perm), .walk_busy(b_busy),
    .fill_valid(b_fill_valid), .fill_asid(b_fill_asid), .fill_vpn(b_fill_vpn),
    .fill_pfn(b_fill_pfn), .fill_perm(3'b111), .flush_we(b_flush_we),
    .flush_cmd(b_flush_cmd), .cfg_we(1'b0), .cfg_wdata(32'h0)
  );

  typedef struct packed { logic hit; logic [19:0] pfn; logic [2:0] perm; } exp_t;
  exp_t  q[$];
  string qtag[$];
  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        check(0, "R2/R4 unexpected response", {8'b0, rsp_hit, rsp_pfn, rsp_perm}, 0);
      end else begin
        exp_t e;
        string t;
        e = q.pop_front();
        t = qtag.pop_front();
        check({rsp_hit, rsp_pfn, rsp_perm} == e, t,
              {8'b0, rsp_hit, rsp_pfn, rsp_perm}, {8'b0, e});
      end
    end
  end

  task automatic lookup(input logic [6:0] a, input logic [31:0] va, input bit h,
                        input logic [19:0] pfn, input logic [2:0] perm, input string tag);
    @(posedge clk); #1;
    lk_valid = 1; lk_asid = a; lk_va = va;
    q.push_back('{h, pfn, perm});
    qtag.push_back(tag);
    @(posedge clk); #1;
    lk_valid = 0;
  endtask

  task automatic fill(input logic [6:0] a, input logic [19:0] vpn,
                      input logic [19:0] pfn, input logic [2:0] perm);
    @(posedge clk); #1;
    fill_valid = 1; fill_asid = a; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm;
    @(posedge clk); #1;
    fill_valid = 0;
  endtask

  task automatic flush(input logic [31:0] cmd);
    @(posedge clk); #1;
    flush_we = 1; flush_cmd = cmd;
    @(posedge clk); #1;
    flush_we = 0;
  endtask

  task automatic cfg(input logic [31:0] w);
    @(posedge clk); #1;
    cfg_we = 1; cfg_wdata = w;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic b_fill(input logic [1:0] a, input logic [19:0] vpn, input logic [19:0] pfn);
    @(posedge clk); #1;
    b_fill_valid = 1; b_fill_asid = a; b_fill_vpn = vpn; b_fill_pfn = pfn;
    @(posedge clk); #1;
    b_fill_valid = 0;
  endtask

  task automatic b_lookup(input logic [1:0] a, input bit h, input logic [19:0] pfn, input string tag);
    @(posedge clk); #1;
    b_lk_valid = 1; b_lk_asid = a; b_lk_va = 32'h0000_1000;
    @(posedge clk); #1;
    b_lk_valid = 0;
    @(negedge clk);
    check(b_rsp_valid && b_rsp_hit == h && (!h || b_rsp_pfn == pfn), tag,
          {10'b0, b_rsp_valid, b_rsp_hit, b_rsp_pfn}, {10'b0, 1'b1, h, pfn});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(lk_ready && !rsp_valid && !walk_busy, "R1 reset outputs",
          {lk_ready, rsp_valid, walk_busy}, 3'b100);
    rst_n = 1;

    lookup(1, 32'h0040_1000, 0, 0, 0, "R1 first lookup misses");
    check(walk_busy == 1, "R3 busy after miss", walk_busy, 1);
    check(lk_ready == 0, "R4 stall without hit-under-miss", lk_ready, 0);
    @(posedge clk); #1; lk_valid = 1; lk_asid = 1; lk_va = 32'h0040_1000;
    @(posedge clk); #1; lk_valid = 0;
    @(negedge clk);
    check(rsp_valid == 0, "R4 stalled lookup not accepted", rsp_valid, 0);
    fill(1, 20'h00401, 20'hAAAAA, 3'b101);
    check(walk_busy == 0 && lk_ready == 1, "R3 fill clears busy", {walk_busy, lk_ready}, 2'b01);
    lookup(1, 32'h0040_1ABC, 1, 20'hAAAAA, 3'b101, "R2 hit after fill");
    lookup(2, 32'h0040_1000, 0, 0, 0, "R2 other asid misses");
    fill(2, 20'h00401, 20'h22222, 3'b111);
    lookup(1, 32'h0040_1000, 1, 20'hAAAAA, 3'b101, "R2 asid1 hit");
    lookup(2, 32'h0040_1000, 1, 20'h22222, 3'b111, "R2 asid2 hit");
    fill(1, 20'h00402, 20'h33333, 3'b110);
    fill(1, 20'h00405, 20'h44444, 3'b011);
    fill(1, 20'h00801, 20'h55555, 3'b001);

    cfg(32'h2000_0008);
    flush(32'h8100_0403);
    lookup(1, 32'h0040_1000, 0, 0, 0, "R8 group flush page 401");
    check(walk_busy == 1 && lk_ready == 1, "R4 hit-under-miss keeps ready",
          {walk_busy, lk_ready}, 2'b11);
    lookup(1, 32'h0040_2000, 0, 0, 0, "R8 group flush page 402");
    lookup(1, 32'h0040_5000, 1, 20'h44444, 3'b011, "R8 other group kept / R4 hit while busy");
    lookup(2, 32'h0040_1000, 1, 20'h22222, 3'b111, "R9 other asid kept");
    lookup(1, 32'h0080_1000, 1, 20'h55555, 3'b001, "R8 other section kept");
    fill(1, 20'h00401, 20'h11111, 3'b100);

    flush(32'h8100_0402);
    lookup(1, 32'h0040_1000, 0, 0, 0, "R8 section flush 401");
    lookup(1, 32'h0040_5000, 0, 0, 0, "R8 section flush 405");
    lookup(1, 32'h0080_1000, 1, 20'h55555, 3'b001, "R8 section 2 kept");
    lookup(2, 32'h0040_1000, 1, 20'h22222, 3'b111, "R9 section flush spares asid2");
    fill(3, 20'h00900, 20'h66666, 3'b111);

    flush(32'h8200_0000);
    lookup(2, 32'h0040_1000, 0, 0, 0, "R9 asid flush");
    lookup(1, 32'h0080_1000, 1, 20'h55555, 3'b001, "R9 asid flush spares asid1");
    lookup(3, 32'h0090_0000, 1, 20'h66666, 3'b111, "R9 asid flush spares asid3");

    flush(32'h0000_0001);
    lookup(1, 32'h0080_1000, 1, 20'h55555, 3'b001, "R8 code 1 flushes nothing");

    flush(32'h0500_0000);
    lookup(1, 32'h0080_1000, 0, 0, 0, "R9 asid field ignored, all flushed");
    lookup(3, 32'h0090_0000, 0, 0, 0, "R8 flush all");

    cfg(32'h2000_0004);
    for (int k = 0; k < 6; k++) fill(3, 20'h00010 + 20'(k), 20'h00010 + 20'(k), 3'b111);
    lookup(3, 32'h0001_0000, 0, 0, 0, "R6 round robin evicted line 0");
    lookup(3, 32'h0001_1000, 0, 0, 0, "R6 round robin evicted line 1");
    lookup(3, 32'h0001_2000, 1, 20'h00012, 3'b111, "R6 line 2 kept");
    lookup(3, 32'h0001_3000, 1, 20'h00013, 3'b111, "R6 line 3 kept");
    lookup(3, 32'h0001_4000, 1, 20'h00014, 3'b111, "R6 fill into line 0");
    lookup(3, 32'h0001_5000, 1, 20'h00015, 3'b111, "R6 fill into line 1");
    fill(3, 20'h00014, 20'hABCDE, 3'b010);
    lookup(3, 32'h0001_4000, 1, 20'hABCDE, 3'b010, "R6 same page overwritten");
    lookup(3, 32'h0001_2000, 1, 20'h00012, 3'b111, "R6 overwrite did not evict");

    cfg(32'h2000_0008);
    fill(3, 20'h00020, 20'h00020, 3'b111);
    cfg(32'h2000_0004);
    lookup(3, 32'h0002_0000, 0, 0, 0, "R5 line above active count hidden");
    fill(3, 20'h00013, 20'h00013, 3'b111);
    cfg(32'h2000_000F);
    lookup(3, 32'h0002_0000, 1, 20'h00020, 3'b111, "R5 line visible again, count clamped");

    @(posedge clk); #1; flush_we = 1; flush_cmd = 32'h0;
    @(posedge clk); #1; flush_we = 0;
    lk_valid = 1; lk_asid = 3; lk_va = 32'h0001_3000;
    q.push_back('{1'b1, 20'h00013, 3'b111});
    qtag.push_back("R7 lookup on apply edge sees old contents");
    @(posedge clk); #1; lk_valid = 0;
    lookup(3, 32'h0001_3000, 0, 0, 0, "R7 flush applied");

    b_fill(2, 20'h00001, 20'h00007);
    b_fill(1, 20'h00001, 20'h00008);
    @(posedge clk); #1; b_flush_we = 1; b_flush_cmd = 32'hC000_0000;
    @(posedge clk); #1; b_flush_we = 0;
    b_lookup(1, 1, 20'h00008, "R10 narrow field spares asid1");
    b_lookup(2, 0, 0, "R10 narrow field flushes asid2");

    repeat (4) @(posedge clk);
    check(q.size() == 0, "R2 all responses seen", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule